// File: doc/BRIEF.md
# Packed Byte Rounding-Average Stream Engine

This block averages two streams of unsigned bytes into a third stream, one byte pair at a time or eight byte pairs at a time. Each of the two source streams and the result stream carries 64-bit words made of eight byte lanes, with valid/ready flow control on every stream. Every result byte is the mean of its two source bytes with halves rounded up, so the block behaves like a packed SIMD byte average instruction applied to whole buffers.

A job is started with a one-cycle start pulse that carries the total element count. The engine first works through the leftover part of the buffer, which is the count modulo 16, one element per beat in lane 0. It then works through the rest in 16-element chunks, each chunk being two consecutive packed beats: the first covers offsets 0 to 7 and the second covers offsets 8 to 15. When the last beat has been transferred, the engine raises done for one cycle and goes back to idle.

Top module: `pavg_stream`

## Requirements
- R1: Every active result lane equals (a + b + 1) >> 1, formed from a 9-bit sum of the unsigned source bytes a and b. For example, 255 and 255 give 255, and 0 and 1 give 1.
- R2: In the packed phase, a single beat computes all eight lanes at once. Lane l uses bits [8l+7:8l] of both sources and writes the same bits of the result.
- R3: In the byte phase, only lane 0 (bits [7:0]) of each source is consumed. Result bits [63:8] are zero, whatever the upper source lanes hold.
- R4: A job with count N first performs N mod 16 byte-phase beats and only then starts packed beats. If N is below 16, no packed beat occurs.
- R5: The packed phase of a job performs exactly 2 * floor(N / 16) beats. Together with R4, the element covered by packed beat k, lane l, is (N mod 16) + 8k + l.
- R6: While busy, the result stream is valid exactly when both source beats are valid. Both sources see ready exactly when a result beat is valid and the result stream is ready. When idle, no stream is valid or ready.
- R7: While the result stream's ready is low, neither source sees ready, and the pending result beat stays unchanged.
- R8: Done is high for exactly one cycle, in the cycle after the last transfer of a job. Busy is low from that cycle onward.
- R9: A start pulse with a count of zero raises done in the cycle after the pulse, and the job consumes no source beat.
- R10: A start pulse that arrives while a job is busy is ignored. The running job keeps its own beat counts.
- R11: After reset the engine is idle, with busy, done, result valid and both source readies all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| i_start | input | 1 | One-cycle pulse that starts a job (used only when idle) |
| i_count | input | 20 | Total element count, sampled with i_start |
| i_a_data | input | 64 | First source word, eight byte lanes |
| i_a_valid | input | 1 | First source word is valid |
| o_a_ready | output | 1 | First source word is taken this cycle |
| i_b_data | input | 64 | Second source word, eight byte lanes |
| i_b_valid | input | 1 | Second source word is valid |
| o_b_ready | output | 1 | Second source word is taken this cycle |
| o_y_data | output | 64 | Result word of rounded averages |
| o_y_valid | output | 1 | Result word is valid |
| i_y_ready | input | 1 | Downstream accepts the result word |
| o_busy | output | 1 | A job is in progress |
| o_done | output | 1 | One-cycle pulse at the end of a job |

## Verification
The main job uses a count of 65536, so that its packed beats cover every pair of byte values exactly once across the lanes. This sweep separates correct rounding, including the 255 + 255 carry, from truncation and from 8-bit wraparound. Shorter jobs are run with counts of 0, 1, 7, 15, 16, 17, 31, 33 and 100. These lengths tell apart the byte-only, packed-only and mixed splits, and they expose any off-by-one in the remainder or chunk counts. Byte-phase beats carry junk in the upper source lanes, and the valid and ready lines are varied from cycle to cycle. This shows that upper-lane data is dropped, that stalls hold the transfer back, and that a start pulse sent in the middle of a job is ignored.

// File: rtl/pavg_pkg.sv
package pavg_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_BYTE = 2'd1,
      ST_PACK = 2'd2
   } pavg_state_t;
endpackage

// File: rtl/pavg_lane.sv
module pavg_lane #(
   parameter int LANE_W = 8
) (
   input  logic [LANE_W-1:0] a,
   input  logic [LANE_W-1:0] b,
   input  logic              en,
   output logic [LANE_W-1:0] y
);
   localparam int SUM_W = LANE_W + 1;

   logic [SUM_W-1:0] sum;

   always_comb begin
      sum = {1'b0, a} + {1'b0, b} + SUM_W'(1);
      y   = en ? sum[SUM_W-1:1] : '0;
   end
endmodule

// File: rtl/pavg_seq.sv
module pavg_seq
   import pavg_pkg::*;
#(
   parameter int CNT_W    = 20,
   parameter int CHUNK_LG = 4,
   parameter int BEAT_LG  = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] count,
   input  logic             fire,
   output logic             busy,
   output logic             byte_mode,
   output logic             done
);
   pavg_state_t         state_q;
   logic [CHUNK_LG-1:0] rem_q;
   logic [CNT_W-1:0]    beats_q;
   logic                done_q;

   logic [CHUNK_LG-1:0] rem_in;
   logic [CNT_W-1:0]    beats_in;

   always_comb begin
      rem_in   = count[CHUNK_LG-1:0];
      beats_in = (count >> CHUNK_LG) << BEAT_LG;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         rem_q   <= '0;
         beats_q <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  rem_q   <= rem_in;
                  beats_q <= beats_in;
                  if (count == '0)
                     done_q <= 1'b1;
                  else if (rem_in != '0)
                     state_q <= ST_BYTE;
                  else
                     state_q <= ST_PACK;
               end
            end
            ST_BYTE: begin
               if (fire) begin
                  rem_q <= rem_q - CHUNK_LG'(1);
                  if (rem_q == CHUNK_LG'(1)) begin
                     if (beats_q == '0) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                     end else begin
                        state_q <= ST_PACK;
                     end
                  end
               end
            end
            ST_PACK: begin
               if (fire) begin
                  beats_q <= beats_q - CNT_W'(1);
                  if (beats_q == CNT_W'(1)) begin
                     state_q <= ST_IDLE;
                     done_q  <= 1'b1;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      busy      = (state_q != ST_IDLE);
      byte_mode = (state_q == ST_BYTE);
      done      = done_q;
   end

   // R8: done lasts one cycle
   a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R8: engine is idle while done is shown
   a_r8_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   // R9: zero count ends at once
   a_r9_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start && count == '0) |=> (done && !busy));
   // R10: a start while busy does not reload the packed count
   a_r10_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !fire) |=> $stable(beats_q));
   // R4: byte phase never follows packed phase
   a_r4_order: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_PACK) |=> (state_q != ST_BYTE));
endmodule

// File: rtl/pavg_stream.sv
module pavg_stream #(
   parameter int LANES       = 8,
   parameter int LANE_W      = 8,
   parameter int CHUNK_BEATS = 2,
   parameter int CNT_W       = 20
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    i_start,
   input  logic [CNT_W-1:0]        i_count,
   input  logic [LANES*LANE_W-1:0] i_a_data,
   input  logic                    i_a_valid,
   output logic                    o_a_ready,
   input  logic [LANES*LANE_W-1:0] i_b_data,
   input  logic                    i_b_valid,
   output logic                    o_b_ready,
   output logic [LANES*LANE_W-1:0] o_y_data,
   output logic                    o_y_valid,
   input  logic                    i_y_ready,
   output logic                    o_busy,
   output logic                    o_done
);
   localparam int DATA_W   = LANES * LANE_W;
   localparam int CHUNK    = LANES * CHUNK_BEATS;
   localparam int CHUNK_LG = $clog2(CHUNK);
   localparam int BEAT_LG  = $clog2(CHUNK_BEATS);

   generate
      if (LANES < 2 || (1 << $clog2(LANES)) != LANES) begin : g_bad_lanes
         $error("LANES must be a power of two of at least 2");
      end
      if (CHUNK_BEATS < 1 || (1 << BEAT_LG) != CHUNK_BEATS) begin : g_bad_beats
         $error("CHUNK_BEATS must be a power of two");
      end
      if (LANE_W < 2) begin : g_bad_width
         $error("LANE_W must be at least 2");
      end
      if (CNT_W <= CHUNK_LG) begin : g_bad_cnt
         $error("CNT_W must exceed log2 of the chunk size");
      end
   endgenerate

   logic busy;
   logic byte_mode;
   logic fire;
   logic both_valid;

   always_comb begin
      both_valid = i_a_valid && i_b_valid;
      o_y_valid  = busy && both_valid;
      fire       = o_y_valid && i_y_ready;
      o_a_ready  = fire;
      o_b_ready  = fire;
      o_busy     = busy;
   end

   pavg_seq #(
      .CNT_W   (CNT_W),
      .CHUNK_LG(CHUNK_LG),
      .BEAT_LG (BEAT_LG)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (i_start),
      .count    (i_count),
      .fire     (fire),
      .busy     (busy),
      .byte_mode(byte_mode),
      .done     (o_done)
   );

   logic [DATA_W-1:0] y_w;

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         logic [LANE_W-1:0] la;
         logic [LANE_W-1:0] lb;
         logic [LANE_W-1:0] ly;
         assign la = i_a_data[l*LANE_W +: LANE_W];
         assign lb = i_b_data[l*LANE_W +: LANE_W];
         if (l == 0) begin : g_head
            pavg_lane #(.LANE_W(LANE_W)) u_lane (
               .a(la), .b(lb), .en(1'b1), .y(ly));
         end else begin : g_tail
            pavg_lane #(.LANE_W(LANE_W)) u_lane (
               .a(la), .b(lb), .en(!byte_mode), .y(ly));
            // R3: upper lanes silent in the byte phase
            a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
               (o_y_valid && byte_mode) |-> (ly == '0));
         end
         assign y_w[l*LANE_W +: LANE_W] = ly;
         // R1: result lies between the two sources
         a_r1_between: assert property (@(posedge clk) disable iff (!rst_n)
            (o_y_valid && (l == 0 || !byte_mode)) |->
               (ly >= ((la < lb) ? la : lb) && ly <= ((la < lb) ? lb : la)));
      end
   endgenerate

   assign o_y_data = y_w;

   // R7: stalled output takes no input
   a_r7_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (o_y_valid && !i_y_ready) |-> (!o_a_ready && !o_b_ready));
   // R6: an input is taken only with a result handed over
   a_r6_take: assert property (@(posedge clk) disable iff (!rst_n)
      o_a_ready |-> (o_y_valid && i_y_ready && i_a_valid && i_b_valid));
   // R6: nothing valid while idle
   a_r6_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !o_busy |-> (!o_y_valid && !o_a_ready));
endmodule

// File: tb/pavg_stream_bench.sv
module pavg_stream_bench;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 190000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        i_start = 1'b0;
   logic [19:0] i_count = '0;
   logic [63:0] i_a_data = '0;
   logic        i_a_valid = 1'b0;
   logic        o_a_ready;
   logic [63:0] i_b_data = '0;
   logic        i_b_valid = 1'b0;
   logic        o_b_ready;
   logic [63:0] o_y_data;
   logic        o_y_valid;
   logic        i_y_ready = 1'b0;
   logic        o_busy;
   logic        o_done;

   int tests = 0;
   int fails = 0;
   int cycles = 0;
   logic [15:0] lfsr = 16'hACE1;

   pavg_stream u_pavg_stream (
      .clk(clk), .rst_n(rst_n), .i_start(i_start), .i_count(i_count),
      .i_a_data(i_a_data), .i_a_valid(i_a_valid), .o_a_ready(o_a_ready),
      .i_b_data(i_b_data), .i_b_valid(i_b_valid), .o_b_ready(o_b_ready),
      .o_y_data(o_y_data), .o_y_valid(o_y_valid), .i_y_ready(i_y_ready),
      .o_busy(o_busy), .o_done(o_done));

   always #(CLK_PERIOD/2) clk = ~clk;

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > WATCHDOG) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
         end
      end
   end

   function automatic logic [7:0] avg8(logic [7:0] x, logic [7:0] y);
      int s;
      s = (int'(x) + int'(y) + 1) / 2;
      return 8'(s);
   endfunction

   function automatic logic [7:0] a_elem(int e, int salt);
      return 8'(e >> 8) + 8'(salt);
   endfunction

   function automatic logic [7:0] b_elem(int e);
      return 8'(e);
   endfunction

   task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic run_job(int n, bit gate, bit poke);
      int rem;
      int total;
      int idx;
      int iter;
      bit va;
      bit vb;
      bit ry;
      bit poked;
      bit ev;
      logic [63:0] exp_y;
      rem   = n % 16;
      total = rem + (n / 16) * 2;
      idx   = 0;
      iter  = 0;
      poked = 0;
      @(negedge clk);
      i_start   = 1'b1;
      i_count   = 20'(n);
      i_a_valid = 1'b0;
      i_b_valid = 1'b0;
      i_y_ready = 1'b0;
      @(negedge clk);
      i_start = 1'b0;
      forever begin
         if (o_done) begin
            // R5 R8: done follows exactly the last beat
            check(idx == total, "R5 R8 beat count at done", 64'(idx), 64'(total));
            check(!o_busy, "R8 idle at done", 64'(o_busy), 64'd0);
            if (n == 0)
               check(iter == 0, "R9 zero count done timing", 64'(iter), 64'd0);
            break;
         end
         if (iter > 60000) begin
            check(0, "R8 job never finished", 64'(idx), 64'(total));
            break;
         end
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         va = gate ? (lfsr[0] | lfsr[1]) : 1'b1;
         vb = gate ? (lfsr[2] | lfsr[3]) : 1'b1;
         ry = gate ? (lfsr[4] | lfsr[5]) : 1'b1;
         if (idx >= total) begin
            va = 1'b0;
            vb = 1'b0;
         end
         i_start = 1'b0;
         if (poke && !poked && idx == total / 2) begin
            i_start = 1'b1;   // R10: must be ignored
            i_count = 20'd5;
            poked   = 1'b1;
         end
         exp_y = '0;
         if (idx < rem) begin
            i_a_data = {{7{8'hC3}}, a_elem(idx, n)};
            i_b_data = {{7{8'h5A}}, b_elem(idx)};
            exp_y    = {56'd0, avg8(a_elem(idx, n), b_elem(idx))};
         end else begin
            for (int l = 0; l < 8; l++) begin
               int e;
               e = rem + (idx - rem) * 8 + l;
               i_a_data[l*8 +: 8] = a_elem(e, n);
               i_b_data[l*8 +: 8] = b_elem(e);
               exp_y[l*8 +: 8]    = avg8(a_elem(e, n), b_elem(e));
            end
         end
         i_a_valid = va;
         i_b_valid = vb;
         i_y_ready = ry;
         #1;
         if (n == 0)
            check(!o_a_ready && !o_b_ready, "R9 no input taken", 64'(o_a_ready), 64'd0);
         check(o_busy, "R8 busy during job", 64'(o_busy), 64'd1);
         ev = va && vb;
         check(o_y_valid == ev, "R6 valid only with both inputs", 64'(o_y_valid), 64'(ev));
         check(o_a_ready == (ev && ry) && o_b_ready == (ev && ry),
               "R6 R7 input ready follows output handshake",
               64'({o_a_ready, o_b_ready}), 64'({ev && ry, ev && ry}));
         if (ev) begin
            if (idx < rem)
               check(o_y_data == exp_y, "R3 R4 byte phase beat", o_y_data, exp_y);
            else
               check(o_y_data == exp_y, "R1 R2 R5 packed beat", o_y_data, exp_y);
            if (ry)
               idx++;
         end
         iter++;
         @(negedge clk);
      end
      i_start   = 1'b0;
      i_a_valid = 1'b0;
      i_b_valid = 1'b0;
      @(negedge clk);
      check(!o_done, "R8 done lasts one cycle", 64'(o_done), 64'd0);
   endtask

   initial begin
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      // R11: reset state
      check(!o_busy && !o_done && !o_y_valid && !o_a_ready && !o_b_ready,
            "R11 reset state",
            64'({o_busy, o_done, o_y_valid, o_a_ready, o_b_ready}), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      run_job(0, 1'b0, 1'b0);
      run_job(1, 1'b0, 1'b0);
      run_job(7, 1'b1, 1'b0);
      run_job(15, 1'b1, 1'b0);
      run_job(16, 1'b0, 1'b0);
      run_job(17, 1'b1, 1'b0);
      run_job(31, 1'b1, 1'b1);
      run_job(33, 1'b1, 1'b0);
      run_job(100, 1'b1, 1'b1);
      run_job(65536, 1'b1, 1'b1);
      run_job(0, 1'b1, 1'b0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule